// File: doc/BRIEF.md
# Oscillator Startup Gate Controller

This block decides when a slow, free-running oscillator clock may be passed on to the logic that uses it. Software sets an enable bit together with a startup-delay select through a single configuration write. The block then counts that many cycles of the oscillator itself, keeping the forwarded clock held low throughout. When the count is done, it opens the clock gate and raises a ready status in the system clock domain. The zero-to-one change of that status can latch an interrupt.

The enable, the startup counter and the ready state are cleared only by the power-on reset. An ordinary system reset clears nothing but a pending interrupt flag, because a crystal can take far longer to start than a system reset cycle lasts. The block also reports which of the two oscillator pins are free for general-purpose use. While the oscillator is off, both pins are free. When it is on and fed from an external clock, only the output-side pin is free.

Top module: `osc_start_gate`

## Requirements
- R1: After power-on reset (porN low), oscReady, irqReq and gatedClk are 0, and pinInFree and pinOutFree are both 1.
- R2: gatedClk stays 0 while the oscillator is not ready. It is 0 whenever oscClk is 0, and it opens or closes only in whole oscillator high phases.
- R3: With startup select s on cfgStartSel (3 bits), ready is set on the oscillator edge after L further enabled edges have been counted. L is 0 for s=0 and 2^(5+s) for s=1..7, which gives 64 up to 4096. oscReady follows through a two-flop synchronizer on sysClk.
- R4: Writing the enable bit to 0 clears the ready state and closes the clock gate.
- R5: A low sysRstN keeps the enable, the count and the ready state as they are. It only clears a pending interrupt flag.
- R6: The interrupt flag is set only on a 0-to-1 change of oscReady while the interrupt-enable bit is 1. A 1-to-0 change of oscReady never sets it.
- R7: irqReq stays 1 until a one-cycle irqClear pulse. If a new ready edge arrives in the same cycle as the clear, setting the flag wins.
- R8: When disabled, pinInFree=1 and pinOutFree=1. When enabled with cfgExtMode=1, pinInFree=0 and pinOutFree=1. When enabled with cfgExtMode=0, both are 0.
- R9: Changing cfgStartSel while the count is running does not change the startup length of that enable period.
- R10: A cycle with cfgWe=1 loads the enable, select, external-mode and interrupt-enable fields together. The pin outputs reflect the write from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock |
| sysRstN | input | 1 | Ordinary system reset, active low, synchronous |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| oscClk | input | 1 | Raw free-running oscillator clock |
| cfgWe | input | 1 | Configuration write strobe |
| cfgEnable | input | 1 | Oscillator enable field |
| cfgStartSel | input | 3 | Startup delay select field |
| cfgExtMode | input | 1 | External-clock mode field |
| cfgIrqEn | input | 1 | Ready-interrupt enable field |
| irqClear | input | 1 | Clears the interrupt flag |
| gatedClk | output | 1 | Glitch-free forwarded oscillator clock |
| oscReady | output | 1 | Ready status, system domain |
| irqReq | output | 1 | Latched interrupt request |
| pinInFree | output | 1 | Input-side oscillator pin free for general use |
| pinOutFree | output | 1 | Output-side oscillator pin free for general use |

## Verification
The hardest situation to reach is a change of the startup select while a long count is already running. Only the length of the ready delay shows whether the new select was ignored. The stimulus starts a 64-cycle startup and rewrites the select to the 4096-cycle setting partway through. It then checks that ready arrives in the short window. The longest setting is also run once in full, and the gate is sampled in both oscillator phases throughout. The sequence also pulses the system reset while an interrupt is pending and the clock is running. It ends with a power-on reset in mid-operation, to show which state survives which reset.

// File: rtl/osg_pkg.sv
package osg_pkg;
  localparam int SEL_W = 3;

  // Control-to-datapath strobes
  typedef struct packed {
    logic             oscOn;
    logic [SEL_W-1:0] startSel;
  } ctlToDp_t;
endpackage

// File: rtl/osg_ctrl.sv
module osg_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     sysClk,
  input  logic                     sysRstN,
  input  logic                     porN,
  input  logic                     cfgWe,
  input  logic                     cfgEnable,
  input  logic [osg_pkg::SEL_W-1:0] cfgStartSel,
  input  logic                     cfgExtMode,
  input  logic                     cfgIrqEn,
  input  logic                     irqClear,
  input  logic                     readyOsc,
  output osg_pkg::ctlToDp_t        toDp,
  output logic                     oscReady,
  output logic                     irqReq,
  output logic                     pinInFree,
  output logic                     pinOutFree
);
  logic                      enReg, extReg, irqEnReg;
  logic [osg_pkg::SEL_W-1:0] selReg;
  logic [SYNC_STAGES-1:0]    rdySync;
  logic                      readyPrev, readyRise, irqFlag;

  // Configuration survives everything but power-on reset
  always_ff @(posedge sysClk or negedge porN) begin
    if (!porN) begin
      enReg    <= 1'b0;
      extReg   <= 1'b0;
      irqEnReg <= 1'b0;
      selReg   <= '0;
    end else if (cfgWe) begin
      enReg    <= cfgEnable;
      extReg   <= cfgExtMode;
      irqEnReg <= cfgIrqEn;
      selReg   <= cfgStartSel;
    end
  end

  always_ff @(posedge sysClk or negedge porN) begin
    if (!porN) begin
      rdySync   <= '0;
      readyPrev <= 1'b0;
    end else begin
      rdySync   <= {rdySync[SYNC_STAGES-2:0], readyOsc};
      readyPrev <= oscReady;
    end
  end

  assign oscReady  = rdySync[SYNC_STAGES-1];
  assign readyRise = oscReady & ~readyPrev;

  always_ff @(posedge sysClk or negedge porN) begin
    if (!porN)                       irqFlag <= 1'b0;
    else if (!sysRstN)               irqFlag <= 1'b0;
    else if (readyRise && irqEnReg)  irqFlag <= 1'b1;
    else if (irqClear)               irqFlag <= 1'b0;
  end

  assign irqReq        = irqFlag;
  assign pinInFree     = ~enReg;
  assign pinOutFree    = ~enReg | extReg;
  assign toDp.oscOn    = enReg;
  assign toDp.startSel = selReg;
endmodule

// File: rtl/osg_datapath.sv
module osg_datapath #(
  parameter int BASE_SHIFT  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              oscClk,
  input  logic              porN,
  input  osg_pkg::ctlToDp_t fromCtl,
  output logic              readyOsc,
  output logic              enSeen,
  output logic              gatedClk
);
  localparam int CNT_W = BASE_SHIFT + (1 << osg_pkg::SEL_W);

  logic [SYNC_STAGES-1:0]    enSync;
  logic [osg_pkg::SEL_W-1:0] selHeld;
  logic [CNT_W-1:0]          cnt, limit;
  logic                      gateEn;

  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) enSync <= '0;
    else       enSync <= {enSync[SYNC_STAGES-2:0], fromCtl.oscOn};
  end
  assign enSeen = enSync[SYNC_STAGES-1];

  always_comb begin
    if (selHeld == '0) limit = '0;
    else               limit = CNT_W'(1) << (BASE_SHIFT + int'(selHeld));
  end

  // Select is captured only while disabled, so mid-count rewrites are ignored
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) begin
      cnt      <= '0;
      readyOsc <= 1'b0;
      selHeld  <= '0;
    end else if (!enSeen) begin
      cnt      <= '0;
      readyOsc <= 1'b0;
      selHeld  <= fromCtl.startSel;
    end else if (!readyOsc) begin
      if (cnt == limit) readyOsc <= 1'b1;
      else              cnt      <= cnt + CNT_W'(1);
    end
  end

  // Transparent while the oscillator clock is low: gate changes only then
  always_latch begin
    if (!porN)        gateEn = 1'b0;
    else if (!oscClk) gateEn = readyOsc;
  end

  assign gatedClk = oscClk & gateEn;
endmodule

// File: rtl/osc_start_gate.sv
module osc_start_gate #(
  parameter int BASE_SHIFT  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      sysClk,
  input  logic                      sysRstN,
  input  logic                      porN,
  input  logic                      oscClk,
  input  logic                      cfgWe,
  input  logic                      cfgEnable,
  input  logic [osg_pkg::SEL_W-1:0] cfgStartSel,
  input  logic                      cfgExtMode,
  input  logic                      cfgIrqEn,
  input  logic                      irqClear,
  output logic                      gatedClk,
  output logic                      oscReady,
  output logic                      irqReq,
  output logic                      pinInFree,
  output logic                      pinOutFree
);
  osg_pkg::ctlToDp_t ctlBus;
  logic              readyOsc;
  logic              dpEnSeen;

  osg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .sysClk(sysClk), .sysRstN(sysRstN), .porN(porN),
    .cfgWe(cfgWe), .cfgEnable(cfgEnable), .cfgStartSel(cfgStartSel),
    .cfgExtMode(cfgExtMode), .cfgIrqEn(cfgIrqEn), .irqClear(irqClear),
    .readyOsc(readyOsc), .toDp(ctlBus), .oscReady(oscReady),
    .irqReq(irqReq), .pinInFree(pinInFree), .pinOutFree(pinOutFree)
  );

  osg_datapath #(.BASE_SHIFT(BASE_SHIFT), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .oscClk(oscClk), .porN(porN), .fromCtl(ctlBus),
    .readyOsc(readyOsc), .enSeen(dpEnSeen), .gatedClk(gatedClk)
  );
endmodule

// File: rtl/osc_start_gate_chk.sv
module osc_start_gate_chk (
  input logic sysClk,
  input logic oscClk,
  input logic porN,
  input logic sysRstN,
  input logic gatedClk,
  input logic oscReady,
  input logic irqReq,
  input logic pinInFree,
  input logic pinOutFree,
  input logic readyOsc,
  input logic enSeen
);
  AST_GATE_LOW_PHASE: assert property (@(posedge sysClk) disable iff (!porN) !oscClk |-> !gatedClk); // R2
  AST_READY_NEEDS_EN: assert property (@(posedge oscClk) disable iff (!porN) $rose(readyOsc) |-> $past(enSeen)); // R4
  AST_IRQ_ON_RISE: assert property (@(posedge sysClk) disable iff (!porN) $rose(irqReq) |-> ($past(oscReady) && !$past(oscReady, 2))); // R6
  AST_SYSRST_DROPS_IRQ: assert property (@(posedge sysClk) disable iff (!porN) !sysRstN |=> !irqReq); // R5
  AST_PIN_ORDER: assert property (@(posedge sysClk) disable iff (!porN) pinInFree |-> pinOutFree); // R8
endmodule

bind osc_start_gate osc_start_gate_chk chk_i (
  .sysClk(sysClk), .oscClk(oscClk), .porN(porN), .sysRstN(sysRstN),
  .gatedClk(gatedClk), .oscReady(oscReady), .irqReq(irqReq),
  .pinInFree(pinInFree), .pinOutFree(pinOutFree),
  .readyOsc(readyOsc), .enSeen(dpEnSeen)
);

// File: tb/osc_start_gate_tb_top.sv
`timescale 1ns/1ps
module osc_start_gate_tb_top;
  logic       sysClk = 1'b0;
  logic       oscClk = 1'b0;
  logic       sysRstN = 1'b1;
  logic       porN = 1'b0;
  logic       cfgWe = 1'b0, cfgEnable = 1'b0, cfgExtMode = 1'b0, cfgIrqEn = 1'b0;
  logic [2:0] cfgStartSel = 3'd0;
  logic       irqClear = 1'b0;
  logic       gatedClk, oscReady, irqReq, pinInFree, pinOutFree;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  osc_start_gate dut_i (
    .sysClk(sysClk), .sysRstN(sysRstN), .porN(porN), .oscClk(oscClk),
    .cfgWe(cfgWe), .cfgEnable(cfgEnable), .cfgStartSel(cfgStartSel),
    .cfgExtMode(cfgExtMode), .cfgIrqEn(cfgIrqEn), .irqClear(irqClear),
    .gatedClk(gatedClk), .oscReady(oscReady), .irqReq(irqReq),
    .pinInFree(pinInFree), .pinOutFree(pinOutFree)
  );

  always #2.5 sysClk = ~sysClk;   // 200 MHz

  // Oscillator edges offset so they never meet a system clock edge
  initial begin
    #1.001;
    forever begin
      oscClk = 1'b1; #18.5;
      oscClk = 1'b0; #18.5;
    end
  end

  // ---------------- reference model ----------------
  bit mEn = 0, mExt = 0, mIrqEn = 0;
  int mSel = 0;
  bit mRdyOsc = 0, mGateOpen = 0, mReady = 0, mPrev = 0, mIrq = 0;
  int mRemain = -1;
  int mSelCap = 0;
  bit enQ[$]  = '{0, 0};
  bit rdyQ[$] = '{0};

  function automatic int startLen(int s);
    return (s == 0) ? 0 : (1 << (5 + s));
  endfunction

  always @(posedge oscClk or negedge porN) begin
    if (!porN) begin
      enQ = '{0, 0}; mRdyOsc = 0; mRemain = -1; mSelCap = 0;
    end else begin
      bit seen;
      seen = enQ.pop_front();
      enQ.push_back(mEn);
      if (!seen) begin
        mRdyOsc = 0; mRemain = -1; mSelCap = mSel;
      end else if (!mRdyOsc) begin
        if (mRemain < 0) mRemain = startLen(mSelCap);
        if (mRemain == 0) mRdyOsc = 1;
        else mRemain--;
      end
    end
  end

  always @(negedge oscClk or negedge porN) begin
    if (!porN) mGateOpen = 0;
    else       mGateOpen = mRdyOsc;
  end

  always @(posedge sysClk or negedge porN) begin
    if (!porN) begin
      mEn = 0; mExt = 0; mIrqEn = 0; mSel = 0;
      rdyQ = '{0}; mReady = 0; mPrev = 0; mIrq = 0;
    end else begin
      bit rise;
      rise = mReady && !mPrev;
      if (!sysRstN)              mIrq = 0;
      else if (rise && mIrqEn)   mIrq = 1;
      else if (irqClear)         mIrq = 0;
      mPrev = mReady;
      rdyQ.push_back(mRdyOsc);
      mReady = rdyQ.pop_front();
      if (cfgWe) begin
        mEn = cfgEnable; mExt = cfgExtMode; mIrqEn = cfgIrqEn; mSel = int'(cfgStartSel);
      end
    end
  end

  task automatic expect1(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compared on every system clock
  always @(negedge sysClk) begin
    if (porN && !done) begin
      expect1("R3", "oscReady", oscReady, mReady);
      expect1("R6", "irqReq", irqReq, mIrq);
      expect1("R8", "pinInFree", pinInFree, !mEn);
      expect1("R8", "pinOutFree", pinOutFree, !mEn || mExt);
    end
  end

  always @(posedge oscClk) begin
    #9;
    if (porN && !done) expect1("R2", "gatedClk high phase", gatedClk, mGateOpen);
  end

  always @(negedge oscClk) begin
    #9;
    if (porN && !done) expect1("R2", "gatedClk low phase", gatedClk, 1'b0);
  end

  // ---------------- stimulus ----------------
  task automatic writeCfg(bit en, int sel, bit ext, bit ie);
    @(negedge sysClk);
    cfgWe = 1; cfgEnable = en; cfgStartSel = 3'(sel); cfgExtMode = ext; cfgIrqEn = ie;
    @(negedge sysClk);
    cfgWe = 0;
  endtask

  task automatic sysCycles(int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic oscCycles(int n);
    repeat (n) @(posedge oscClk);
    @(negedge sysClk);
  endtask

  task automatic pulseClear();
    @(negedge sysClk); irqClear = 1;
    @(negedge sysClk); irqClear = 0;
  endtask

  task automatic pulseSysRst();
    @(negedge sysClk); sysRstN = 0;
    @(negedge sysClk); sysRstN = 1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #900000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired at %0t", $time);
      finishRun();
    end
  end

  initial begin
    porN = 0;
    sysCycles(10);
    @(negedge sysClk); porN = 1;
    sysCycles(20);
    // R1 reset state
    expect1("R1", "oscReady", oscReady, 0);
    expect1("R1", "irqReq", irqReq, 0);
    expect1("R1", "pinInFree", pinInFree, 1);
    expect1("R1", "pinOutFree", pinOutFree, 1);
    expect1("R1", "gatedClk", gatedClk, 0);

    // R10 fields load together; R3 select 0
    writeCfg(1, 0, 0, 1);
    expect1("R10", "pinInFree after write", pinInFree, 0);
    expect1("R10", "pinOutFree after write", pinOutFree, 0);
    oscCycles(6);
    expect1("R3", "ready with select 0", oscReady, 1);
    sysCycles(4);
    expect1("R6", "irq on ready rise", irqReq, 1);
    sysCycles(100);
    expect1("R7", "irq held", irqReq, 1);
    pulseClear();
    expect1("R7", "irq cleared", irqReq, 0);

    // R4 disable; R6 no interrupt on fall
    writeCfg(0, 0, 0, 1);
    oscCycles(6);
    expect1("R4", "ready cleared on disable", oscReady, 0);
    expect1("R4", "gate closed", gatedClk, 0);
    expect1("R6", "no irq on fall", irqReq, 0);
    expect1("R8", "pins free when off", pinInFree & pinOutFree, 1);

    // R8 external mode; R9 select rewrite mid-count
    writeCfg(1, 1, 1, 1);
    expect1("R8", "ext pinIn", pinInFree, 0);
    expect1("R8", "ext pinOut", pinOutFree, 1);
    oscCycles(20);
    writeCfg(1, 7, 1, 1);
    oscCycles(30);
    expect1("R9", "not yet ready", oscReady, 0);
    oscCycles(30);
    expect1("R9", "ready at first select", oscReady, 1);
    sysCycles(4);
    expect1("R6", "irq after second rise", irqReq, 1);

    // R5 system reset keeps ready, drops pending irq
    pulseSysRst();
    sysCycles(2);
    expect1("R5", "ready kept", oscReady, 1);
    expect1("R5", "irq dropped", irqReq, 0);
    expect1("R5", "enable kept", pinInFree, 0);
    oscCycles(4);
    expect1("R5", "still ready", oscReady, 1);

    // R6 interrupt disabled
    writeCfg(0, 2, 0, 0);
    oscCycles(6);
    writeCfg(1, 2, 0, 0);
    oscCycles(140);
    expect1("R3", "ready at select 2", oscReady, 1);
    expect1("R6", "no irq when masked", irqReq, 0);

    // R3 longest select
    writeCfg(0, 7, 0, 1);
    oscCycles(6);
    writeCfg(1, 7, 0, 1);
    oscCycles(4000);
    expect1("R3", "not ready before 4096", oscReady, 0);
    oscCycles(200);
    expect1("R3", "ready after 4096", oscReady, 1);
    sysCycles(4);
    expect1("R6", "irq after long start", irqReq, 1);

    // R1 power-on reset mid-run
    @(negedge sysClk); porN = 0;
    sysCycles(5);
    @(negedge sysClk); porN = 1;
    sysCycles(3);
    expect1("R1", "por ready", oscReady, 0);
    expect1("R1", "por irq", irqReq, 0);
    expect1("R1", "por pinIn", pinInFree, 1);
    expect1("R1", "por pinOut", pinOutFree, 1);
    oscCycles(10);
    expect1("R1", "por stays off", oscReady, 0);

    finishRun();
  end
endmodule